// File: doc/BRIEF.md
# Release-Acquire Ordering Controller

This block sits between a request stream and a memory port and enforces release consistency on what it lets through. Each request is tagged as an ordinary access, an acquire or a release. Ordinary accesses are not ordered among themselves and may complete out of order. An acquire closes the gate behind itself: nothing that comes after it may issue until the acquire has completed. A release looks only backwards. It waits until every earlier ordinary access has completed, and accesses that come after it are free to issue in the meantime.

Later accesses must not hold up a release, so ordinary accesses are counted in two epochs. Accepting a release flips the current epoch. The release is held in a one-entry slot until the counter of the epoch it closed drains to zero. Each ordinary access leaves with its epoch bit, and its completion must return that same bit so that the right counter is decremented. Completions of acquires and releases are reported by kind. Only one release is in flight at a time, and only one acquire.

Top module: `relacq_order_ctrl`

## Requirements
- R1: After a synchronous reset, or a reset applied in the middle of activity, nothing is offered downstream, no acquire or release is pending, both counters are zero and the current epoch is 0. An ordinary request is then accepted whenever `dn_ready` is high.
- R2: An ordinary request (`up_kind` 2'b00) is forwarded in the same cycle. `dn_valid` follows `up_valid`, `up_ready` follows `dn_ready`, and `dn_epoch` carries the current epoch.
- R3: After an acquire (`up_kind` 2'b01) is issued, `up_ready` stays low for every kind of request until a completion with `cpl_kind` 2'b01 arrives. It rises in the cycle after that completion.
- R4: A release (`up_kind` 2'b10) is accepted into the slot without being offered downstream in that cycle. It does not depend on `dn_ready`, and it flips the current epoch.
- R5: A held release is offered downstream only once the counter of the epoch it closed is zero. Completions carrying the other epoch do not advance it.
- R6: Ordinary accesses that arrive after a release issue while the release is still held. They carry the new epoch.
- R7: While a release is held, or has been issued and has not yet completed (`cpl_kind` 2'b10), a further release gets `up_ready` low.
- R8: A release that is ready to issue has priority on the downstream port. Upstream ordinary and acquire requests get `up_ready` low while it is offered. It stays offered, with its kind and epoch unchanged, until `dn_ready`.
- R9: When the counter of the current epoch holds 2^CNT_W-1 (31 by default), an ordinary request is not offered and `up_ready` stays low. A completion in that same cycle lifts the stall only from the next cycle.
- R10: The payload of a release is presented unchanged on `dn_data` when the release issues. Forwarded requests present their own `up_data`.
- R11: Kind code 2'b11 is handled as an ordinary access. It is counted in the current epoch and passed downstream with its code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_kind | input | 2 | 00 ordinary, 01 acquire, 10 release, 11 ordinary |
| up_data | input | DATA_W | Request payload |
| dn_valid | output | 1 | Downstream issue valid |
| dn_ready | input | 1 | Downstream accepts the issue |
| dn_kind | output | 2 | Kind of the issued access |
| dn_data | output | DATA_W | Payload of the issued access |
| dn_epoch | output | 1 | Epoch tag of the issued access |
| cpl_valid | input | 1 | A completion is reported |
| cpl_kind | input | 2 | Kind of the completed access |
| cpl_epoch | input | 1 | Epoch tag returned with an ordinary completion |

## Verification
A scripted table feeds ordinary requests that meet backpressure, and then a release with earlier accesses still outstanding. Ordinary completions are returned out of order across both epochs, which shows that only the closed epoch gates the release while new ordinary traffic still issues. An acquire is sent while a release is held, which separates the forward-only block of the acquire from the backward wait of the release. The held release is shown issuing under that acquire. Directed runs fill an epoch counter to its limit, including a completion in the stall cycle, and assert reset while an acquire is outstanding.

// File: rtl/relacq_pkg.sv
package relacq_pkg;

   typedef enum logic [1:0] {
      KIND_ORD     = 2'b00,
      KIND_ACQ     = 2'b01,
      KIND_REL     = 2'b10,
      KIND_ORD_ALT = 2'b11
   } kind_e;

   localparam int NUM_EPOCHS = 2;

   function automatic logic kind_is_acq(input logic [1:0] k);
      return k == KIND_ACQ;
   endfunction

   function automatic logic kind_is_rel(input logic [1:0] k);
      return k == KIND_REL;
   endfunction

   function automatic logic kind_is_ord(input logic [1:0] k);
      return !kind_is_acq(k) && !kind_is_rel(k);
   endfunction

endpackage

// File: rtl/relacq_epoch_cnt.sv
module relacq_epoch_cnt #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] count
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("relacq_epoch_cnt: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign count = count_q;

endmodule

// File: rtl/relacq_rel_slot.sv
module relacq_rel_slot #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              load_ep,
   input  logic [DATA_W-1:0] load_data,
   input  logic              fire,
   input  logic              done,
   output logic              held,
   output logic              busy,
   output logic              ep,
   output logic [DATA_W-1:0] data
);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("relacq_rel_slot: DATA_W must be at least 1");
      end
   endgenerate

   logic              held_q;
   logic              busy_q;
   logic              ep_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         held_q <= 1'b0;
         busy_q <= 1'b0;
         ep_q   <= 1'b0;
         data_q <= '0;
      end else begin
         if (load) begin
            held_q <= 1'b1;
            busy_q <= 1'b1;
            ep_q   <= load_ep;
            data_q <= load_data;
         end else begin
            if (fire) begin
               held_q <= 1'b0;
            end
            if (done) begin
               busy_q <= 1'b0;
            end
         end
      end
   end

   assign held = held_q;
   assign busy = busy_q;
   assign ep   = ep_q;
   assign data = data_q;

endmodule

// File: rtl/relacq_acq_track.sv
module relacq_acq_track (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic pending
);

   logic pending_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pending_q <= 1'b0;
      end else if (set) begin
         pending_q <= 1'b1;
      end else if (clr) begin
         pending_q <= 1'b0;
      end
   end

   assign pending = pending_q;

endmodule

// File: rtl/relacq_order_ctrl.sv
module relacq_order_ctrl
   import relacq_pkg::*;
#(
   parameter int CNT_W  = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [1:0]        up_kind,
   input  logic [DATA_W-1:0] up_data,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [1:0]        dn_kind,
   output logic [DATA_W-1:0] dn_data,
   output logic              dn_epoch,
   input  logic              cpl_valid,
   input  logic [1:0]        cpl_kind,
   input  logic              cpl_epoch
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("relacq_order_ctrl: CNT_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("relacq_order_ctrl: DATA_W must be at least 1");
      end
   endgenerate

   // epoch state and per-epoch counters
   logic                  epoch_q;
   logic [CNT_W-1:0]      cnt_q [NUM_EPOCHS];
   logic [NUM_EPOCHS-1:0] inc_v;
   logic [NUM_EPOCHS-1:0] dec_v;
   logic [NUM_EPOCHS-1:0] full_v;
   logic [NUM_EPOCHS-1:0] empty_v;

   // release slot and acquire tracker
   logic              rel_held;
   logic              rel_busy;
   logic              rel_ep;
   logic [DATA_W-1:0] rel_data;
   logic              acq_out;

   // decoded request and completion
   logic up_is_ord;
   logic up_is_acq;
   logic up_is_rel;
   logic cpl_is_ord;
   logic cpl_is_acq;
   logic cpl_is_rel;

   logic slot_go;
   logic ord_room;
   logic pass_ok;
   logic up_fire;
   logic ord_issue;
   logic acq_issue;
   logic rel_load;
   logic rel_fire;

   always_comb begin
      up_is_ord  = kind_is_ord(up_kind);
      up_is_acq  = kind_is_acq(up_kind);
      up_is_rel  = kind_is_rel(up_kind);
      cpl_is_ord = cpl_valid && kind_is_ord(cpl_kind);
      cpl_is_acq = cpl_valid && kind_is_acq(cpl_kind);
      cpl_is_rel = cpl_valid && kind_is_rel(cpl_kind);
   end

   // a held release may go once its closed epoch has drained
   assign slot_go  = rel_held && empty_v[rel_ep];
   assign ord_room = !full_v[epoch_q];
   assign pass_ok  = !acq_out && !slot_go && (!up_is_ord || ord_room);

   always_comb begin
      if (acq_out) begin
         up_ready = 1'b0;
      end else if (up_is_rel) begin
         up_ready = !rel_busy;
      end else begin
         up_ready = pass_ok && dn_ready;
      end
   end

   always_comb begin
      dn_valid = slot_go || (up_valid && !up_is_rel && pass_ok);
      if (slot_go) begin
         dn_kind  = KIND_REL;
         dn_data  = rel_data;
         dn_epoch = rel_ep;
      end else begin
         dn_kind  = up_kind;
         dn_data  = up_data;
         dn_epoch = epoch_q;
      end
   end

   assign up_fire   = up_valid && up_ready;
   assign ord_issue = up_fire && up_is_ord;
   assign acq_issue = up_fire && up_is_acq;
   assign rel_load  = up_fire && up_is_rel;
   assign rel_fire  = slot_go && dn_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         epoch_q <= 1'b0;
      end else if (rel_load) begin
         epoch_q <= !epoch_q;
      end
   end

   generate
      for (genvar e = 0; e < NUM_EPOCHS; e++) begin : g_epoch
         assign inc_v[e]   = ord_issue && (epoch_q == 1'(e));
         assign dec_v[e]   = cpl_is_ord && (cpl_epoch == 1'(e));
         assign full_v[e]  = (cnt_q[e] == CNT_MAX);
         assign empty_v[e] = (cnt_q[e] == '0);

         relacq_epoch_cnt #(
            .CNT_W (CNT_W)
         ) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (inc_v[e]),
            .dec   (dec_v[e]),
            .count (cnt_q[e])
         );
      end
   endgenerate

   relacq_rel_slot #(
      .DATA_W (DATA_W)
   ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .load      (rel_load),
      .load_ep   (epoch_q),
      .load_data (up_data),
      .fire      (rel_fire),
      .done      (cpl_is_rel),
      .held      (rel_held),
      .busy      (rel_busy),
      .ep        (rel_ep),
      .data      (rel_data)
   );

   relacq_acq_track u_acq (
      .clk     (clk),
      .rst     (rst),
      .set     (acq_issue),
      .clr     (cpl_is_acq),
      .pending (acq_out)
   );

endmodule

// File: rtl/relacq_order_chk.sv
module relacq_order_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst,
   input logic             up_ready,
   input logic [1:0]       up_kind,
   input logic             dn_valid,
   input logic             dn_ready,
   input logic [1:0]       dn_kind,
   input logic             dn_epoch,
   input logic             acq_out,
   input logic             rel_busy,
   input logic             rel_ep,
   input logic [CNT_W-1:0] cnt0,
   input logic [CNT_W-1:0] cnt1
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   AST_ACQ_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      acq_out |-> !up_ready); // R3

   AST_REL_DRAINED: assert property (@(posedge clk) disable iff (rst)
      (dn_valid && dn_kind == 2'b10) |-> ((rel_ep ? cnt1 : cnt0) == '0)); // R5

   AST_ONE_REL: assert property (@(posedge clk) disable iff (rst)
      (rel_busy && up_kind == 2'b10) |-> !up_ready); // R7

   AST_REL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (dn_valid && !dn_ready && dn_kind == 2'b10) |=> (dn_valid && dn_kind == 2'b10)); // R8

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (dn_valid && dn_ready && dn_kind != 2'b01 && dn_kind != 2'b10)
         |-> ((dn_epoch ? cnt1 : cnt0) != CNT_MAX)); // R9

endmodule

bind relacq_order_ctrl relacq_order_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .up_ready (up_ready),
   .up_kind  (up_kind),
   .dn_valid (dn_valid),
   .dn_ready (dn_ready),
   .dn_kind  (dn_kind),
   .dn_epoch (dn_epoch),
   .acq_out  (acq_out),
   .rel_busy (rel_busy),
   .rel_ep   (rel_ep),
   .cnt0     (cnt_q[0]),
   .cnt1     (cnt_q[1])
);

// File: tb/relacq_order_ctrl_test.sv
module relacq_order_ctrl_test;

   localparam int CNT_W  = 5;
   localparam int DATA_W = 8;
   localparam int NVEC   = 27;
   localparam int CNT_LIM = (1 << CNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              up_valid = 1'b0;
   logic              up_ready;
   logic [1:0]        up_kind = 2'b00;
   logic [DATA_W-1:0] up_data = '0;
   logic              dn_valid;
   logic              dn_ready = 1'b0;
   logic [1:0]        dn_kind;
   logic [DATA_W-1:0] dn_data;
   logic              dn_epoch;
   logic              cpl_valid = 1'b0;
   logic [1:0]        cpl_kind = 2'b00;
   logic              cpl_epoch = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   relacq_order_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst(rst),
      .up_valid(up_valid), .up_ready(up_ready), .up_kind(up_kind), .up_data(up_data),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_kind(dn_kind), .dn_data(dn_data),
      .dn_epoch(dn_epoch),
      .cpl_valid(cpl_valid), .cpl_kind(cpl_kind), .cpl_epoch(cpl_epoch)
   );

   // {uv, uk[1:0], dr, cv, ck[1:0], ce, exp_ur, exp_dv, exp_dk[1:0], exp_de}
   localparam logic [12:0] VEC [NVEC] = '{
      13'b1_00_1_0_00_0_1_1_00_0, //  0 R2 ordinary forwarded
      13'b1_00_0_0_00_0_0_1_00_0, //  1 R2 backpressure
      13'b1_00_1_0_00_0_1_1_00_0, //  2 R2
      13'b1_10_1_0_00_0_1_0_00_0, //  3 R4 release parked, epoch flips
      13'b1_00_1_0_00_0_1_1_00_1, //  4 R6 later ordinary passes held release
      13'b1_10_1_0_00_0_0_0_00_0, //  5 R7 second release stalled
      13'b0_00_0_1_00_0_0_0_00_0, //  6 R5 one old completion
      13'b0_00_0_1_00_1_0_0_00_0, //  7 R5 new-epoch completion does not help
      13'b0_00_0_1_00_0_0_0_00_0, //  8 R5 last old completion
      13'b1_00_0_0_00_0_0_1_10_0, //  9 R8 release wins port, held by ready
      13'b1_00_1_0_00_0_0_1_10_0, // 10 R8 R10 release issues
      13'b1_10_1_0_00_0_0_0_00_0, // 11 R7 release in flight
      13'b1_11_1_0_00_0_1_1_11_1, // 12 R11 code 3 as ordinary
      13'b0_00_0_1_10_0_0_0_00_0, // 13 R7 release completes
      13'b1_10_1_0_00_0_1_0_00_0, // 14 R4 release closing epoch 1
      13'b1_01_1_0_00_0_1_1_01_0, // 15 R3 acquire issues
      13'b1_00_1_0_00_0_0_0_00_0, // 16 R3 blocked behind acquire
      13'b0_00_0_1_00_1_0_0_00_0, // 17 R3 R11 code-3 access completes
      13'b0_00_1_0_00_0_0_1_10_1, // 18 R5 release issues under acquire
      13'b1_00_1_1_01_0_0_0_00_0, // 19 R3 acquire completes this cycle
      13'b1_00_1_0_00_0_1_1_00_0, // 20 R3 unblocked
      13'b1_10_1_0_00_0_0_0_00_0, // 21 R7 release not yet completed
      13'b0_00_0_1_10_0_0_0_00_0, // 22 R7
      13'b1_10_1_0_00_0_1_0_00_0, // 23 R4
      13'b0_00_0_1_00_0_0_0_00_0, // 24 R5
      13'b0_00_1_0_00_0_0_1_10_0, // 25 R5 R10
      13'b0_00_0_1_10_0_0_0_00_0  // 26
   };

   task automatic drive(input logic uv, input logic [1:0] uk, input logic [DATA_W-1:0] ud,
                        input logic dr, input logic cv, input logic [1:0] ck, input logic ce);
      @(negedge clk);
      up_valid  = uv;
      up_kind   = uk;
      up_data   = ud;
      dn_ready  = dr;
      cpl_valid = cv;
      cpl_kind  = ck;
      cpl_epoch = ce;
      #1;
   endtask

   task automatic check_hs(input string req, input logic xur, input logic xdv);
      n_tests++;
      if (up_ready !== xur || dn_valid !== xdv) begin
         n_fail++;
         $display("FAIL %s: up_ready/dn_valid actual=%b%b expected=%b%b",
                  req, up_ready, dn_valid, xur, xdv);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      up_valid = 1'b0; dn_ready = 1'b0; cpl_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      int rel_idx;
      rel_idx = 0;
      do_reset();

      // R1: idle after reset
      drive(1'b0, 2'b00, '0, 1'b1, 1'b0, 2'b00, 1'b0);
      check_hs("R1 idle", 1'b1, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         logic [12:0] v;
         v = VEC[i];
         drive(v[12], v[11:10], DATA_W'(i), v[9], v[8], v[7:6], v[5]);
         n_tests++;
         if (up_ready !== v[4] || dn_valid !== v[3] ||
             (v[3] && (dn_kind !== v[2:1] || dn_epoch !== v[0] ||
                       dn_data !== (v[2:1] == 2'b10 ? DATA_W'(rel_idx) : DATA_W'(i))))) begin
            n_fail++;
            $display("FAIL vec %0d (R2..R11 see table): rdy=%b vld=%b kind=%b ep=%b data=%0d expected rdy=%b vld=%b kind=%b ep=%b",
                     i, up_ready, dn_valid, dn_kind, dn_epoch, dn_data,
                     v[4], v[3], v[2:1], v[0]);
         end
         if (v[12] && v[4] && v[11:10] == 2'b10) rel_idx = i;
      end

      // R9: fill epoch counter to its limit
      do_reset();
      for (int k = 0; k < CNT_LIM; k++) begin
         drive(1'b1, 2'b00, '0, 1'b1, 1'b0, 2'b00, 1'b0);
         check_hs("R9 fill", 1'b1, 1'b1);
      end
      drive(1'b1, 2'b00, '0, 1'b1, 1'b0, 2'b00, 1'b0);
      check_hs("R9 at limit", 1'b0, 1'b0);
      drive(1'b1, 2'b00, '0, 1'b1, 1'b1, 2'b00, 1'b0);
      check_hs("R9 completion same cycle", 1'b0, 1'b0);
      drive(1'b1, 2'b00, '0, 1'b1, 1'b0, 2'b00, 1'b0);
      check_hs("R9 room again", 1'b1, 1'b1);

      // R1: reset while an acquire is outstanding and counter nearly full
      drive(1'b1, 2'b01, '0, 1'b1, 1'b0, 2'b00, 1'b0);
      check_hs("R1 acquire before reset", 1'b1, 1'b1);
      drive(1'b1, 2'b00, '0, 1'b1, 1'b0, 2'b00, 1'b0);
      check_hs("R3 blocked before reset", 1'b0, 1'b0);
      do_reset();
      drive(1'b0, 2'b00, '0, 1'b0, 1'b0, 2'b00, 1'b0);
      check_hs("R1 no issue after reset", 1'b0, 1'b0);
      drive(1'b1, 2'b00, '0, 1'b1, 1'b0, 2'b00, 1'b0);
      check_hs("R1 ordinary after reset", 1'b1, 1'b1);
      n_tests++;
      if (dn_epoch !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 epoch after reset: actual=%b expected=0", dn_epoch);
      end

      @(negedge clk);
      up_valid = 1'b0;
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL R1 watchdog: cycles actual=20000 expected<20000");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule